// File: doc/BRIEF.md
# Interrupt-Driven Single-Item Transfer Engine

This block answers peripheral service requests by copying a single byte or a single 16-bit word from one memory location to another. No software handler runs for these copies. It has eight channels. Each channel keeps a source pointer, a destination pointer, a transfer counter and three control bits.

A granted request borrows the memory bus for one service. A service is a read cycle at the source pointer followed directly by a write cycle at the destination pointer. At the end of the service, the block advances one of the two pointers and counts down the channel's counter. A channel whose counter has run out no longer copies. Its next request is turned into a per-channel interrupt line, which stays raised until software acknowledges it.

Software sets up each channel through a small register port. The port uses a channel number, a field select, a write strobe and write data. The field the port addresses is always readable on the read-data output. Field select values are: 0 control, 1 source pointer, 2 destination pointer, 3 counter. The memory side is a synchronous port. Read data arrives one clock after the read cycle. Byte reads return the byte in bits 7:0.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: A one-clock pulse on a channel's request input makes that channel pending on the next clock. Further pulses that arrive while the channel is still pending are merged, so only one service follows.
- R2: When several channels are pending and the engine is idle, the lowest-numbered pending channel is taken first. The others stay pending and are taken later in ascending order.
- R3: Each service uses exactly two consecutive bus clocks, with the steal output high in both. The first clock is a read at the source pointer. The second is a write at the destination pointer carrying the data just read.
- R4: Control bit 0 selects the item size, 1 for a 16-bit word and 0 for a byte. A byte service writes only the destination byte, and the byte next to it is left unchanged.
- R5: After a service, the selected pointer moves forward by 2 in word mode or by 1 in byte mode, and the other pointer is left unchanged. Control bit 1 makes this selection: 1 advances the destination pointer, 0 advances the source pointer.
- R6: When control bit 2 is 0, each service decrements the channel's counter by exactly one.
- R7: When control bit 2 (continuous mode) is 1, the counter never changes, and services continue on every request, even with a counter of zero.
- R8: A request that is taken while the counter is zero and continuous mode is off causes no bus cycle and leaves both pointers unchanged. On the following clock, the channel's interrupt output is raised.
- R9: An interrupt output stays high until software writes that channel's counter or writes its control field with bit 3 set. A control write with bit 3 clear leaves it high.
- R10: After reset, every channel field reads 0, nothing is pending, and the bus request, steal and interrupt outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Per-channel service request pulses |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | CHW | Channel addressed by the register port |
| cfg_sel_i | input | 2 | Field select: 0 control, 1 source, 2 destination, 3 counter |
| cfg_wdata_i | input | DW | Register write data |
| cfg_rdata_o | output | DW | Current value of the addressed field (control reads bits 2:0) |
| mem_req_o | output | 1 | Bus cycle active |
| mem_we_o | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_word_o | output | 1 | 1 for a word access, 0 for a byte access |
| mem_addr_o | output | AW | Byte address of the bus cycle |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid one clock after a read cycle |
| steal_o | output | 1 | High while a service holds the bus |
| irq_o | output | NCH | Per-channel exhausted-counter interrupt |

## Verification
The bound checker monitors several properties on every clock:
- the read-then-write pairing of each service;
- that at most one grant is made, and that it goes to the lowest pending channel;
- that request pulses always register as pending;
- that an exhausted-counter hit never reaches the bus and always raises its interrupt;
- that an interrupt only drops after a register write.

Some behaviour only the bench's scenarios can show:
- that the right bytes land at the destination for every channel, size and pointer choice;
- the exact pointer and counter values after each service;
- the order of the destination addresses under simultaneous requests;
- the merging of a repeated request;
- the continuous-mode counter staying still;
- which register write does or does not acknowledge an interrupt.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_state_e;

  // Packed so that bit 0 = word, bit 1 = advance destination, bit 2 = continuous
  typedef struct packed {
    logic cont;
    logic inc_dst;
    logic word;
  } chan_ctrl_t;

  localparam int unsigned CTL_BITS    = 3;
  localparam int unsigned CTL_CLR_BIT = 3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  // Pointer stride for one item
  function automatic logic [1:0] ptr_step(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction

  // Counter exhausted: no more copies, next request becomes an interrupt
  function automatic logic cnt_exhausted(input logic is_zero, input logic cont);
    return is_zero && !cont;
  endfunction

endpackage

// File: rtl/evt_xfer_arb.sv
module evt_xfer_arb #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  // Fixed priority: lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

endmodule

// File: rtl/evt_xfer_chan.sv
module evt_xfer_chan
  import evt_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          take_i,
  input  logic          upd_i,
  input  logic          zero_hit_i,
  input  logic          wr_ctrl_i,
  input  logic          wr_src_i,
  input  logic          wr_dst_i,
  input  logic          wr_cnt_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output chan_ctrl_t    ctrl_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o,
  output logic          empty_o
);

  logic          pend_q;
  chan_ctrl_t    ctrl_q;
  logic [AW-1:0] src_q;
  logic [AW-1:0] dst_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [AW-1:0] stride;
  logic          ack;

  assign stride = AW'(ptr_step(ctrl_q.word));
  assign ack    = wr_cnt_i || (wr_ctrl_i && wdata_i[CTL_CLR_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~take_i) | req_i;

      if (wr_ctrl_i) ctrl_q <= chan_ctrl_t'(wdata_i[CTL_BITS-1:0]);

      if (wr_src_i)                         src_q <= wdata_i[AW-1:0];
      else if (upd_i && !ctrl_q.inc_dst)    src_q <= src_q + stride;

      if (wr_dst_i)                         dst_q <= wdata_i[AW-1:0];
      else if (upd_i && ctrl_q.inc_dst)     dst_q <= dst_q + stride;

      if (wr_cnt_i)                         cnt_q <= wdata_i[CW-1:0];
      else if (upd_i && !ctrl_q.cont)       cnt_q <= cnt_q - 1'b1;

      if (ack)                              done_q <= 1'b0;
      else if (zero_hit_i)                  done_q <= 1'b1;
    end
  end

  assign pend_o  = pend_q;
  assign ctrl_o  = ctrl_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign done_o  = done_q;
  assign empty_o = cnt_exhausted(cnt_q == '0, ctrl_q.cont);

endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl
  import evt_xfer_pkg::*;
#(
  parameter  int NCH = 8,
  parameter  int AW  = 16,
  parameter  int CW  = 8,
  parameter  int DW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [1:0]     cfg_sel_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  output logic [DW-1:0]  cfg_rdata_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic           mem_word_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           steal_o,
  output logic [NCH-1:0] irq_o
);

  // Named internal events, observed by the bound checker
  logic [NCH-1:0] pend_vec;
  logic [NCH-1:0] empty_vec;
  logic [NCH-1:0] gnt_vec;
  logic [NCH-1:0] take_vec;
  logic [NCH-1:0] upd_vec;
  logic [NCH-1:0] zero_hit_vec;
  logic [CHW-1:0] gnt_idx;
  logic           gnt_any;
  logic           start_xfer;

  xfer_state_e    state_q;
  logic [CHW-1:0] cur_q;

  chan_ctrl_t     ctrl_a [NCH];
  logic [AW-1:0]  src_a  [NCH];
  logic [AW-1:0]  dst_a  [NCH];
  logic [CW-1:0]  cnt_a  [NCH];

  evt_xfer_arb #(.N(NCH)) u_arb (
    .req_i (pend_vec),
    .gnt_o (gnt_vec),
    .idx_o (gnt_idx),
    .any_o (gnt_any)
  );

  assign take_vec     = (state_q == ST_IDLE) ? gnt_vec : '0;
  assign zero_hit_vec = take_vec & empty_vec;
  assign start_xfer   = (state_q == ST_IDLE) && gnt_any && !empty_vec[gnt_idx];
  assign upd_vec      = (state_q == ST_WR) ? (NCH'(1) << cur_q) : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = cfg_we_i && (cfg_ch_i == CHW'(g));

    evt_xfer_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i[g]),
      .take_i     (take_vec[g]),
      .upd_i      (upd_vec[g]),
      .zero_hit_i (zero_hit_vec[g]),
      .wr_ctrl_i  (hit && (cfg_sel_i == SEL_CTRL)),
      .wr_src_i   (hit && (cfg_sel_i == SEL_SRC)),
      .wr_dst_i   (hit && (cfg_sel_i == SEL_DST)),
      .wr_cnt_i   (hit && (cfg_sel_i == SEL_CNT)),
      .wdata_i    (cfg_wdata_i),
      .pend_o     (pend_vec[g]),
      .ctrl_o     (ctrl_a[g]),
      .src_o      (src_a[g]),
      .dst_o      (dst_a[g]),
      .cnt_o      (cnt_a[g]),
      .done_o     (irq_o[g]),
      .empty_o    (empty_vec[g])
    );
  end

  // Service sequencer: idle -> read -> write -> idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_xfer) begin
          cur_q   <= gnt_idx;
          state_q <= ST_RD;
        end
        ST_RD:   state_q <= ST_WR;
        ST_WR:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_word_o  = ctrl_a[cur_q].word;
  assign mem_addr_o  = (state_q == ST_WR) ? dst_a[cur_q] : src_a[cur_q];
  assign mem_wdata_o = mem_rdata_i;
  assign steal_o     = (state_q != ST_IDLE);

  always_comb begin
    unique case (cfg_sel_i)
      SEL_CTRL: cfg_rdata_o = DW'(ctrl_a[cfg_ch_i]);
      SEL_SRC:  cfg_rdata_o = DW'(src_a[cfg_ch_i]);
      SEL_DST:  cfg_rdata_o = DW'(dst_a[cfg_ch_i]);
      default:  cfg_rdata_o = DW'(cnt_a[cfg_ch_i]);
    endcase
  end

endmodule

// File: rtl/evt_xfer_chk.sv
module evt_xfer_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we_i,
  input logic [NCH-1:0] req_i,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic           steal_o,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] pend_vec,
  input logic [NCH-1:0] take_vec,
  input logic [NCH-1:0] zero_hit_vec
);

  assert_req_pends_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((pend_vec & $past(req_i)) == $past(req_i)));

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec));

  assert_lowest_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec != '0) |-> (((take_vec & pend_vec) == take_vec) &&
                          (((take_vec - 1'b1) & pend_vec) == '0)));

  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));

  assert_write_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_req_o);

  assert_steal_starts_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steal_o) |-> (mem_req_o && !mem_we_o));

  assert_zero_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit_vec != '0) |=> !mem_req_o);

  assert_zero_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((zero_hit_vec != '0) && !cfg_we_i) |=>
      ((irq_o & $past(zero_hit_vec)) == $past(zero_hit_vec)));

  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq_o & $past(irq_o)) != '0) |-> $past(cfg_we_i));

endmodule

bind evt_xfer_ctrl evt_xfer_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we_i     (cfg_we_i),
  .req_i        (req_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .steal_o      (steal_o),
  .irq_o        (irq_o),
  .pend_vec     (pend_vec),
  .take_vec     (take_vec),
  .zero_hit_vec (zero_hit_vec)
);

// File: tb/evt_xfer_ctrl_tb.sv
module evt_xfer_ctrl_tb;

  localparam int NCH = 8;
  localparam int AW  = 16;
  localparam int CW  = 8;
  localparam int DW  = 16;
  localparam int CHW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] req = '0;
  logic           cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [1:0]     cfg_sel = 2'd0;
  logic [DW-1:0]  cfg_wdata = '0;
  logic [DW-1:0]  cfg_rdata;
  logic           mem_req, mem_we, mem_word;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata;
  logic [DW-1:0]  mem_rdata = '0;
  logic           steal;
  logic [NCH-1:0] irq;

  always #4 clk = ~clk;

  evt_xfer_ctrl #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_word_o(mem_word),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .steal_o(steal), .irq_o(irq)
  );

  // Byte-addressed 256-byte memory model, one-clock read latency
  logic [7:0] mem [256];
  logic [7:0] a0, a1;
  assign a0 = mem_addr[7:0];
  assign a1 = a0 + 8'd1;

  always @(posedge clk) begin
    if (mem_req && !mem_we)
      mem_rdata <= mem_word ? {mem[a1], mem[a0]} : {8'h00, mem[a0]};
    if (mem_req && mem_we) begin
      mem[a0] = mem_wdata[7:0];
      if (mem_word) mem[a1] = mem_wdata[15:8];
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int steal_cycles = 0;
  int wr_n = 0;
  int wr_log [16];

  always @(negedge clk) begin
    if (steal) steal_cycles++;
    if (mem_req && mem_we) begin
      wr_log[wr_n % 16] = int'(mem_addr);
      wr_n++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int ch, input logic [1:0] sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = sel; cfg_wdata = DW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int ch, input logic [1:0] sel, output int v);
    @(negedge clk);
    cfg_ch = CHW'(ch); cfg_sel = sel;
    #1 v = int'(cfg_rdata);
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ch, input int ctl, input int s, input int d, input int c);
    cfg_wr(ch, 2'd0, ctl);
    cfg_wr(ch, 2'd1, s);
    cfg_wr(ch, 2'd2, d);
    cfg_wr(ch, 2'd3, c);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
    idle(3);
    rst_n = 1'b1;

    // R10: reset state
    for (int ch = 0; ch < NCH; ch++)
      for (int s = 0; s < 4; s++) begin
        cfg_rd(ch, 2'(s), v);
        chk("R10 field reset", v, 0);
      end
    chk("R10 irq reset", int'(irq), 0);
    chk("R10 steal reset", int'(steal), 0);
    chk("R10 mem_req reset", int'(mem_req), 0);

    // R3 R4 R5 R6: sweep all channels, sizes and pointer choices
    for (int ch = 0; ch < NCH; ch++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++) begin
          int src, dst, p0, p1, stp;
          src = ch * 16; dst = 128 + ch * 16;
          p0 = (ch * 29 + w * 7 + d * 3 + 1) & 255;
          p1 = (~p0) & 255;
          mem[src] = 8'(p0); mem[src+1] = 8'(p1);
          for (int k = 0; k < 4; k++) mem[dst+k] = 8'h00;
          setup(ch, (d << 1) | w, src, dst, 3);
          steal_cycles = 0;
          pulse(NCH'(1) << ch);
          idle(4);
          stp = w ? 2 : 1;
          chk("R3 dst low byte", int'(mem[dst]), p0);
          chk("R4 dst next byte", int'(mem[dst+1]), w ? p1 : 0);
          chk("R3 steal cycles", steal_cycles, 2);
          cfg_rd(ch, 2'd1, v); chk("R5 src ptr", v, d ? src : src + stp);
          cfg_rd(ch, 2'd2, v); chk("R5 dst ptr", v, d ? dst + stp : dst);
          cfg_rd(ch, 2'd3, v); chk("R6 count", v, 2);
        end

    // R2: simultaneous requests served lowest first
    setup(2, 0, 32, 160, 5);
    setup(5, 0, 80, 208, 5);
    setup(6, 0, 96, 224, 5);
    wr_n = 0;
    pulse(8'b0110_0100);
    idle(12);
    chk("R2 service count", wr_n, 3);
    chk("R2 first", wr_log[0], 160);
    chk("R2 second", wr_log[1], 208);
    chk("R2 third", wr_log[2], 224);
    cfg_rd(6, 2'd3, v); chk("R2 last count", v, 4);

    // R1: repeated request while pending is merged
    setup(0, 0, 0, 128, 5);
    setup(3, 0, 48, 176, 5);
    wr_n = 0;
    pulse(8'b0000_1001);
    pulse(8'b0000_1000);
    idle(10);
    chk("R1 merged services", wr_n, 2);
    cfg_rd(3, 2'd3, v); chk("R1 ch3 count", v, 4);
    cfg_rd(0, 2'd3, v); chk("R1 ch0 count", v, 4);

    // R8: exhausted counter turns the request into an interrupt
    setup(4, 0, 64, 192, 1);
    pulse(8'b0001_0000); idle(4);
    cfg_rd(4, 2'd3, v); chk("R6 count to zero", v, 0);
    chk("R8 no irq yet", int'(irq[4]), 0);
    steal_cycles = 0;
    pulse(8'b0001_0000); idle(4);
    chk("R8 no bus cycle", steal_cycles, 0);
    chk("R8 irq raised", int'(irq[4]), 1);
    cfg_rd(4, 2'd1, v); chk("R8 src unchanged", v, 65);
    cfg_rd(4, 2'd3, v); chk("R8 count stays", v, 0);

    // R9: interrupt acknowledge rules
    cfg_wr(4, 2'd0, 0); idle(1);
    chk("R9 ctrl write w/o clear keeps irq", int'(irq[4]), 1);
    cfg_wr(4, 2'd0, 8); idle(1);
    chk("R9 clear bit drops irq", int'(irq[4]), 0);
    pulse(8'b0001_0000); idle(4);
    chk("R9 irq again", int'(irq[4]), 1);
    cfg_wr(4, 2'd3, 2); idle(1);
    chk("R9 count write drops irq", int'(irq[4]), 0);
    cfg_rd(4, 2'd3, v); chk("R9 count written", v, 2);

    // R7: continuous mode, counter frozen even at zero
    setup(7, 4, 112, 240, 0);
    wr_n = 0;
    for (int k = 0; k < 3; k++) begin
      pulse(8'b1000_0000); idle(4);
    end
    chk("R7 services", wr_n, 3);
    cfg_rd(7, 2'd1, v); chk("R7 src advanced", v, 115);
    cfg_rd(7, 2'd3, v); chk("R7 count frozen", v, 0);
    chk("R7 no irq", int'(irq[7]), 0);
    chk("R7 last byte", int'(mem[240]), int'(mem[114]));
    cfg_wr(7, 2'd3, 6);
    pulse(8'b1000_0000); idle(4);
    cfg_rd(7, 2'd3, v); chk("R7 nonzero count frozen", v, 6);

    finish_run();
  end

endmodule